// File: doc/BRIEF.md
# Eight-Channel Staggered PWM Generator

This block drives eight pulse-width modulated outputs from one shared count. A prescaler divides the clock by a programmable amount from 1 to 256. Each prescaler tick moves a shared counter forward. The period is a power of two from 32 to 256 counts, and it can be shortened by one count. Each channel compares the counter with its own duty byte, masked to the active data width. It then drives the result through its own enable and polarity controls. New duty values are held in a shadow register and take effect only when a cycle wraps.

Adjacent channels form pairs. A pair can be switched into alternating mode: on one cycle only the even channel of the pair may pulse, and on the next cycle only the odd one. A phase bit that software can read shows which member is active. A cycle interrupt sets a sticky flag, either at the last count of the period or one count before it. Writing a one to the flag clears it. Software reaches all of this through a byte-wide register bus that has combinational read data.

Two small state machines carry the sequencing. The alternation machine has the states PH_EVEN and PH_ODD. At every cycle wrap it moves PH_EVEN to PH_ODD or PH_ODD to PH_EVEN, and at all other times it stays put. The flag machine has the states FLG_IDLE and FLG_PENDING. It moves FLG_IDLE to FLG_PENDING when the chosen trigger count ends. It moves FLG_PENDING to FLG_IDLE on a clearing write that lands in a cycle without a trigger. Otherwise it holds its state.

Top module: `pwm_stagger8`

## Requirements
- R1: After reset every register reads 0, all outputs are low, irq is low, and the alternation phase is PH_EVEN.
- R2: Register map. Address 0x0 holds the enables and 0x1 the polarities, with bit i for channel i. Address 0x2 is the configuration: bit 0 shortens the period, bits 3:2 hold the width code, bit 1 is the phase, and bits 7:4 enable alternation for pairs 0/1, 2/3, 4/5 and 6/7. Address 0x3 is the divisor. Addresses 0x4 to 0xB hold the duty bytes of channels 0 to 7. Address 0xC is interrupt control: bit 0 enables the interrupt, bit 1 selects the early point, bit 7 is the flag, and its other bits read 0.
- R3: With width code 00, 01, 10 or 11 the cycle is 256, 128, 64 or 32 counts. Setting configuration bit 0 makes it one count shorter. The counter always wraps to 0 after its last count.
- R4: A channel is active while the counter is below its duty byte masked to the active width. It is therefore active for min(masked duty, period) counts per cycle, and a duty of 0 leaves it idle.
- R5: With polarity 0 the output idles low and is high while active. With polarity 1 it idles high and is low while active. A disabled channel stays at its idle level.
- R6: The counter advances once every D clocks, where D is the divisor byte, and a divisor of 0 means 256 clocks.
- R7: A duty write takes effect only at the next cycle wrap. The cycle already in progress finishes with the old value.
- R8: The phase bit toggles at every cycle wrap. For a pair in alternation mode, phase 0 holds the odd channel idle and phase 1 holds the even channel idle. Pairs that are not in this mode are unaffected.
- R9: Bus writes to configuration bit 1 have no effect on the phase.
- R10: With interrupt-point bit 0 the flag sets when the last count ends. With bit 1 it sets when the count before the last ends. irq is high only while the flag and the enable bit are both set.
- R11: Writing 1 to bit 7 of 0xC clears the flag, and writing 0 there leaves it set. A trigger in the same cycle as the clearing write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, one byte per asserted cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pwm_out | output | 8 | Channel outputs, bit i is channel i |
| irq | output | 1 | Cycle interrupt request |

## Verification
The assertions check on every clock several behaviours that must hold from cycle to cycle:
- disabled channels stay at their idle level;
- the two members of an alternating pair are never active together;
- the phase toggles exactly at a wrap and nowhere else;
- the counter holds between ticks and wraps after its last count;
- the shadow duty values stay stable within a cycle;
- the flag sets after a trigger and clears after a write-one.

Only the bench scenarios can show the quantities that span a whole period. These are the active time under each width, shortening and masking combination, the period length for each divisor including divide-by-256, the exact count at which each interrupt point fires, and the deferred takeover of a duty written in mid-cycle.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    localparam int BUS_W  = 8;
    localparam int CH_N   = 8;
    localparam int PAIRS  = CH_N / 2;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_POLAR  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CONFIG = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_DIVIDE = ADDR_W'(3);
    localparam int                DUTY0    = 4;
    localparam logic [ADDR_W-1:0] A_IRQCTL = ADDR_W'(DUTY0 + CH_N);

    typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;
    typedef enum logic {FLG_IDLE = 1'b0, FLG_PENDING = 1'b1} flag_e;
endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
    import pwm8_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    input  logic [BUS_W-1:0]      wdata,
    output logic [BUS_W-1:0]      rdata,
    input  logic                  phase,
    input  logic                  flag_set,
    output logic [CH_N-1:0]       en,
    output logic [CH_N-1:0]       pol,
    output logic                  cycsel,
    output logic [1:0]            mode,
    output logic [PAIRS-1:0]      stag,
    output logic [BUS_W-1:0]      div,
    output logic [CH_N*BUS_W-1:0] duty_flat,
    output logic                  ie,
    output logic                  pre,
    output logic                  flag
);
    logic [BUS_W-1:0] duty_q [CH_N];
    flag_e            flg_q, flg_d;
    logic             clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= '0;
            pol    <= '0;
            cycsel <= 1'b0;
            mode   <= 2'b00;
            stag   <= '0;
            div    <= '0;
            ie     <= 1'b0;
            pre    <= 1'b0;
        end else if (we) begin
            if (addr == A_ENABLE) en <= wdata[CH_N-1:0];
            if (addr == A_POLAR)  pol <= wdata[CH_N-1:0];
            if (addr == A_CONFIG) begin
                cycsel <= wdata[0];
                mode   <= wdata[3:2];
                stag   <= wdata[4 +: PAIRS];
            end
            if (addr == A_DIVIDE) div <= wdata;
            if (addr == A_IRQCTL) begin
                ie  <= wdata[0];
                pre <= wdata[1];
            end
        end
    end

    for (genvar g = 0; g < CH_N; g++) begin : g_duty
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                duty_q[g] <= '0;
            else if (we && addr == ADDR_W'(DUTY0 + g))
                duty_q[g] <= wdata;
        end
        assign duty_flat[g*BUS_W +: BUS_W] = duty_q[g];
    end

    // Sticky cycle flag: state register
    assign clr = we && (addr == A_IRQCTL) && wdata[BUS_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= FLG_IDLE;
        else        flg_q <= flg_d;
    end

    // Sticky cycle flag: transitions and output
    always_comb begin
        flg_d = flg_q;
        unique case (flg_q)
            FLG_IDLE:    if (flag_set)         flg_d = FLG_PENDING;
            FLG_PENDING: if (!flag_set && clr) flg_d = FLG_IDLE;
        endcase
    end

    assign flag = (flg_q == FLG_PENDING);

    always_comb begin
        rdata = '0;
        if (addr == A_ENABLE) rdata = en;
        if (addr == A_POLAR)  rdata = pol;
        if (addr == A_CONFIG) rdata = {stag, mode, phase, cycsel};
        if (addr == A_DIVIDE) rdata = div;
        if (addr == A_IRQCTL) rdata = {flag, 5'b0, pre, ie};
        for (int i = 0; i < CH_N; i++)
            if (addr == ADDR_W'(DUTY0 + i)) rdata = duty_q[i];
    end
endmodule

// File: rtl/pwm8_timebase.sv
module pwm8_timebase
    import pwm8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] div,
    input  logic [1:0]       mode,
    input  logic             cycsel,
    input  logic             pre,
    output logic [BUS_W-1:0] cnt,
    output logic [BUS_W-1:0] mask,
    output logic [BUS_W-1:0] last,
    output logic             tick,
    output logic             cyc_end,
    output logic             flag_set,
    output logic             phase
);
    logic [BUS_W:0]   full;
    logic [BUS_W-1:0] pre_cnt;
    logic             at_last, at_pre;
    phase_e           ph_q, ph_d;

    assign full    = (BUS_W+1)'(1 << BUS_W) >> mode;
    assign mask    = BUS_W'(full - (BUS_W+1)'(1));
    assign last    = BUS_W'(full - (BUS_W+1)'(1) - (BUS_W+1)'(cycsel));
    assign tick    = (pre_cnt >= (div - BUS_W'(1)));
    assign at_last = (cnt >= last);
    assign at_pre  = (cnt == (last - BUS_W'(1)));
    assign cyc_end  = tick && at_last;
    assign flag_set = tick && (pre ? at_pre : at_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            cnt     <= '0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + BUS_W'(1);
            if (tick) cnt <= at_last ? '0 : cnt + BUS_W'(1);
        end
    end

    // Alternation phase: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_EVEN;
        else        ph_q <= ph_d;
    end

    // Alternation phase: transitions and output
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_EVEN: if (cyc_end) ph_d = PH_ODD;
            PH_ODD:  if (cyc_end) ph_d = PH_EVEN;
        endcase
    end

    assign phase = (ph_q == PH_ODD);
endmodule

// File: rtl/pwm8_chan.sv
module pwm8_chan
    import pwm8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] duty_in,
    input  logic             load,
    input  logic [BUS_W-1:0] cnt,
    input  logic [BUS_W-1:0] mask,
    input  logic             en,
    input  logic             pol,
    input  logic             allow,
    output logic [BUS_W-1:0] shadow,
    output logic             out
);
    logic active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shadow <= '0;
        else if (load) shadow <= duty_in;
    end

    assign active = en && allow && (cnt < (shadow & mask));
    assign out    = active ^ pol;
endmodule

// File: rtl/pwm_stagger8.sv
module pwm_stagger8
    import pwm8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CH_N-1:0]   pwm_out,
    output logic              irq
);
    logic [CH_N-1:0]       en_q, pol_q, allow;
    logic                  cycsel_q, ie_q, pre_q, flag_q, phase_q;
    logic [1:0]            mode_q;
    logic [PAIRS-1:0]      stag_q;
    logic [BUS_W-1:0]      div_q, cnt_q, mask_q, last_q;
    logic [CH_N*BUS_W-1:0] duty_flat, duty_sh;
    logic                  tick, cyc_end, flag_set;

    pwm8_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .rdata(bus_rdata), .phase(phase_q),
        .flag_set(flag_set), .en(en_q), .pol(pol_q), .cycsel(cycsel_q),
        .mode(mode_q), .stag(stag_q), .div(div_q), .duty_flat(duty_flat),
        .ie(ie_q), .pre(pre_q), .flag(flag_q)
    );

    pwm8_timebase u_tb (
        .clk(clk), .rst_n(rst_n), .div(div_q), .mode(mode_q),
        .cycsel(cycsel_q), .pre(pre_q), .cnt(cnt_q), .mask(mask_q),
        .last(last_q), .tick(tick), .cyc_end(cyc_end),
        .flag_set(flag_set), .phase(phase_q)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        // even member runs in phase 0, odd member in phase 1
        assign allow[g] = !stag_q[g/2] || (phase_q == ((g % 2) == 1));

        pwm8_chan u_ch (
            .clk(clk), .rst_n(rst_n),
            .duty_in(duty_flat[g*BUS_W +: BUS_W]), .load(cyc_end),
            .cnt(cnt_q), .mask(mask_q), .en(en_q[g]), .pol(pol_q[g]),
            .allow(allow[g]), .shadow(duty_sh[g*BUS_W +: BUS_W]),
            .out(pwm_out[g])
        );
    end

    assign irq = flag_q && ie_q;
endmodule

// File: rtl/pwm8_checker.sv
module pwm8_checker
    import pwm8_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_we,
    input logic [BUS_W-1:0]      bus_wdata,
    input logic [CH_N-1:0]       pwm_out,
    input logic [CH_N-1:0]       en,
    input logic [CH_N-1:0]       pol,
    input logic [PAIRS-1:0]      stag,
    input logic                  phase,
    input logic                  cyc_end,
    input logic                  flag_set,
    input logic                  flag,
    input logic                  tick,
    input logic [BUS_W-1:0]      cnt,
    input logic [BUS_W-1:0]      last,
    input logic [CH_N*BUS_W-1:0] duty_sh
);
    logic [CH_N-1:0]  act;
    logic [PAIRS-1:0] clash;
    logic             clr_wr;

    assign act    = pwm_out ^ pol;
    assign clr_wr = bus_we && (bus_addr == A_IRQCTL) && bus_wdata[BUS_W-1];

    always_comb
        for (int k = 0; k < PAIRS; k++)
            clash[k] = stag[k] && act[2*k] && act[2*k+1];

    p_disabled_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act & ~en) == '0);
    p_stagger_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clash == '0);
    p_phase_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (phase != $past(phase)));
    p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(phase));
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt >= last) |=> (cnt == '0));
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(duty_sh));
    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> flag);
    p_flag_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !flag_set) |=> !flag);
endmodule

bind pwm_stagger8 pwm8_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pwm_out(pwm_out), .en(en_q), .pol(pol_q),
    .stag(stag_q), .phase(phase_q), .cyc_end(cyc_end),
    .flag_set(flag_set), .flag(flag_q), .tick(tick), .cnt(cnt_q),
    .last(last_q), .duty_sh(duty_sh)
);

// File: tb/sim_pwm_stagger8.sv
module sim_pwm_stagger8;
    localparam int CLK_P = 10;
    // entry: {en, pol, cycsel, mode[1:0], duty[7:0]}
    localparam logic [12:0] TBL [8] = '{
        {1'b1, 1'b0, 1'b0, 2'd0, 8'd128},
        {1'b1, 1'b0, 1'b1, 2'd0, 8'd255},
        {1'b1, 1'b1, 1'b0, 2'd1, 8'd200},
        {1'b1, 1'b0, 1'b1, 2'd2, 8'd63},
        {1'b1, 1'b1, 1'b0, 2'd3, 8'd0},
        {1'b1, 1'b0, 1'b1, 2'd3, 8'h3F},
        {1'b0, 1'b1, 1'b0, 2'd2, 8'd40},
        {1'b1, 1'b0, 1'b0, 2'd0, 8'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    wire  [7:0] rdata, pwm_out;
    wire        irq;

    int checks = 0, errors = 0;
    logic [7:0] pol_m = '0, ctrl_m = 8'h01, rv;
    int act [8];
    logic ph_mid, ph_end, irq_late, irq_end, ph_a;

    pwm_stagger8 u0 (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm_out), .irq(irq));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input int a, input int e);
        checks++;
        if (a != e) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, a, e);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Align on the flag, then sample one full cycle of L clocks
    task automatic measure(input int L, input bit mid, input logic [3:0] ma,
                           input logic [7:0] md);
        for (int c = 0; c < 8; c++) act[c] = 0;
        wr(4'hC, ctrl_m | 8'h80);
        while (irq !== 1'b1) @(negedge clk);
        for (int i = 0; i < L; i++) begin
            for (int c = 0; c < 8; c++)
                if (pwm_out[c] !== pol_m[c]) act[c]++;
            if (i == 0) begin addr = 4'hC; wdata = ctrl_m | 8'h80; we = 1'b1; end
            else if (i == 1) begin we = 1'b0; addr = 4'h2; end
            else if (i == 2) ph_mid = rdata[1];
            else if (i == 4 && mid) begin addr = ma; wdata = md; we = 1'b1; end
            else if (i == 5) begin we = 1'b0; addr = 4'h2; end
            if (i == L - 1) irq_late = irq;
            @(negedge clk);
        end
        irq_end = irq;
        ph_end  = rdata[1];
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R6 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 13; a++) begin
            rd(4'(a), rv);
            chk("R1 reset register", int'(rv), 0);
        end
        chk("R1 reset outputs", int'(pwm_out), 0);
        chk("R1 reset irq", int'(irq), 0);
        @(negedge clk);

        // R2 register map readback
        wr(4'h3, 8'h5A); rd(4'h3, rv); chk("R2 divisor", int'(rv), 'h5A);
        @(negedge clk);
        wr(4'h1, 8'h3C); rd(4'h1, rv); chk("R2 polarity", int'(rv), 'h3C);
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            wr(4'(4 + i), 8'((i * 37 + 11) & 255));
            rd(4'(4 + i), rv);
            chk("R2 duty", int'(rv), (i * 37 + 11) & 255);
            @(negedge clk);
        end
        wr(4'hC, 8'h7E); rd(4'hC, rv); chk("R2 irq control", int'(rv & 8'h7F), 'h02);
        @(negedge clk);
        wr(4'h2, 8'hFE); rd(4'h2, rv); chk("R2 config", int'(rv & 8'hFD), 'hFC);
        @(negedge clk);

        wr(4'h3, 8'h01); wr(4'h1, 8'h00); pol_m = 8'h00;
        ctrl_m = 8'h01; wr(4'hC, 8'h81);
        for (int i = 0; i < 8; i++) wr(4'(4 + i), 8'h00);

        // R3 R4 R5 vector table on channel 0
        for (int e = 0; e < 8; e++) begin
            logic en_b, pol_b, cs_b;
            logic [1:0] md_b;
            logic [7:0] du_b;
            int p, dm, ex;
            {en_b, pol_b, cs_b, md_b, du_b} = TBL[e];
            pol_m = {7'b0, pol_b};
            wr(4'h0, {7'b0, en_b});
            wr(4'h1, pol_m);
            wr(4'h2, {4'b0, md_b, 1'b0, cs_b});
            wr(4'h4, du_b);
            p  = (256 >> md_b) - int'(cs_b);
            dm = int'(du_b) & ((256 >> md_b) - 1);
            ex = en_b ? ((dm < p) ? dm : p) : 0;
            measure(p, 1'b0, 4'h0, 8'h00);
            chk("R4 R5 active count ch0", act[0], ex);
            for (int c = 1; c < 8; c++) chk("R5 disabled channel idle", act[c], 0);
            chk("R3 no wrap before period end", int'(irq_late), 0);
            chk("R3 wrap at period end", int'(irq_end), 1);
        end
        pol_m = 8'h00; wr(4'h1, 8'h00);

        // R8 alternating pair 0/1, channel 2 independent
        wr(4'h2, 8'h1C); wr(4'h0, 8'h07);
        wr(4'h4, 8'd16); wr(4'h5, 8'd16); wr(4'h6, 8'd10);
        for (int r = 0; r < 2; r++) begin
            measure(32, 1'b0, 4'h0, 8'h00);
            chk("R8 even member", act[0], ph_mid ? 0 : 16);
            chk("R8 odd member", act[1], ph_mid ? 16 : 0);
            chk("R8 independent channel", act[2], 10);
            chk("R8 phase toggles at wrap", int'(ph_end), int'(!ph_mid));
        end
        // R9 phase bit not writable
        rd(4'h2, rv); ph_a = rv[1];
        @(negedge clk);
        wr(4'h2, 8'h1C | {6'b0, !ph_a, 1'b0});
        rd(4'h2, rv);
        chk("R9 phase write ignored", int'(rv[1]), int'(ph_a));
        chk("R9 other config bits", int'(rv & 8'hFD), 'h1C);
        @(negedge clk);

        // R7 duty takes effect at the wrap
        wr(4'h2, 8'h0C); wr(4'h0, 8'h01); wr(4'h4, 8'd8);
        measure(32, 1'b0, 4'h0, 8'h00);
        chk("R7 settled duty", act[0], 8);
        measure(32, 1'b1, 4'h4, 8'd20);
        chk("R7 old duty during write cycle", act[0], 8);
        measure(32, 1'b0, 4'h0, 8'h00);
        chk("R7 new duty after wrap", act[0], 20);

        // R6 divisor 3 and divisor 0 (256)
        wr(4'h3, 8'd3);
        measure(96, 1'b0, 4'h0, 8'h00);
        chk("R6 divide by 3 active", act[0], 60);
        chk("R6 divide by 3 period", int'(irq_end), 1);
        wr(4'h3, 8'd0);
        measure(8192, 1'b0, 4'h0, 8'h00);
        chk("R6 divide by 256 active", act[0], 5120);
        chk("R6 divide by 256 period", int'(irq_end), 1);
        wr(4'h3, 8'd1);

        // R10 interrupt point
        wr(4'h2, 8'h00); wr(4'h4, 8'd255);
        measure(256, 1'b0, 4'h0, 8'h00);
        chk("R4 duty 255 in 256 period", act[0], 255);
        ctrl_m = 8'h03; wr(4'hC, 8'h83);
        while (irq !== 1'b1) @(negedge clk);
        chk("R10 early point at last count", int'(pwm_out[0]), 0);
        @(negedge clk);
        chk("R10 early point then wrap", int'(pwm_out[0]), 1);
        ctrl_m = 8'h01; wr(4'hC, 8'h81);
        while (irq !== 1'b1) @(negedge clk);
        chk("R10 normal point at wrap", int'(pwm_out[0]), 1);
        wr(4'hC, 8'h00);
        chk("R10 irq gated by enable", int'(irq), 0);
        rd(4'hC, rv);
        chk("R11 zero write keeps flag", int'(rv[7]), 1);
        @(negedge clk);
        wr(4'hC, 8'h80);
        rd(4'hC, rv);
        chk("R11 one write clears flag", int'(rv[7]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule